// File: doc/BRIEF.md
# Logic Fabric Configuration Sequencer

This block takes a programmable logic fabric from power-up to user mode. Software arms the configuration path with two enable bits and a start request. The sequencer then runs a strict order of steps. It waits out a power-on interval once after reset. It drives the fabric's active-low program line high, then low for at least a minimum pulse width and until the fabric's init line reads low. It releases the program line and waits for init to return high. Only after that does it accept configuration words on a valid/ready stream and pass them to the fabric.

When the fabric raises its done line during loading, the sequencer sets a sticky done bit in a write-one-to-clear interrupt status register. It also raises its interrupt output and enters user mode. Each wait on the fabric is bounded by a timeout. A timeout sets a sticky error bit and returns the sequencer to idle. A fresh start request while a configuration is under way aborts the transfer and restarts from the program pulse.

A four-bit register port exposes the controls, the status and the interrupt status:
- Address 0, control:
  - bit0: port enable.
  - bit1: reconfiguration select.
  - bit2: idle program-line level.
  - bit3: start, write-only.
- Address 1, status, read-only:
  - bit0: synchronised init.
  - bit1: synchronised done.
  - bit2: busy.
  - bit3: user mode.
- Address 2, interrupt status:
  - bit0: done.
  - bit1: timeout.
- Address 3 reads zero.

Top module: `fabric_cfg_seq`

## Requirements
- R1: A write to address 0 starts a sequence only when bits 3, 0 and 1 of the written word are all 1. A write with bit 3 set but bit 0 or bit 1 clear leaves the sequencer idle: status bit2 stays 0 and the program line does not move.
- R2: The first sequence after reset holds the program line high for at least POR_CYCLES cycles before pulling it low. Later sequences skip this wait and pull the line low in fewer than POR_CYCLES cycles.
- R3: The program line stays low for at least PULSE_MIN cycles, and is released only after the synchronised init input reads 0.
- R4: `cfg_ready` is 1 only in the load state. That state is entered only after the program line has been released and init has read 1. Ready is never high while the program line is low or init is low.
- R5: Each word accepted with `cfg_valid` and `cfg_ready` both high at a clock edge appears on `fab_data` with `fab_we` high in the next cycle, in acceptance order.
- R6: Done read high during loading sets interrupt status bit0 and raises `irq`, and the sequencer enters user mode (status bit3 = 1).
- R7: Interrupt status bits are sticky. Writing 1 to a bit at address 2 clears it, writing 0 leaves it, and `irq` is the OR of the bits.
- R8: If init fails to fall, init fails to rise, or no word arrives and done stays low, for TIMEOUT cycles, interrupt status bit1 is set. The sequencer then returns to idle (status bit2 = 0), and the program line returns to the control bit2 level.
- R9: A start request during loading drops `cfg_ready` at once and restarts from the program pulse. The following load delivers a fresh word sequence.
- R10: In idle, `fab_prog_n` follows control bit2, which resets to 1.
- R11: Status bit0 and bit1 report the fabric's init and done lines after a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Registered read data for `reg_addr` |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_data | input | DATA_W | Configuration word |
| cfg_ready | output | 1 | Word accepted this cycle when valid |
| fab_prog_n | output | 1 | Active-low program line to the fabric |
| fab_init | input | 1 | Fabric init status (open-drain, high = ready) |
| fab_done | input | 1 | Fabric done status (open-drain) |
| fab_data | output | DATA_W | Word passed to the fabric |
| fab_we | output | 1 | Write strobe for `fab_data` |
| irq | output | 1 | Interrupt, OR of interrupt status bits |

## Verification
The bench drives a small fabric model whose init and done lines respond to the program line and to the word count. A clean first configuration shows that the power-on wait, the pulse width and the init ordering hold. A restart mid-load shows that the power-on wait is skipped and the transfer is aborted and rerun with new words. A fabric whose init never falls shows that the timeout path leaves the done bit alone and goes back to idle. Start writes that lack an enable bit, and manual program-line writes in idle, show that idle control is kept apart from the sequencer.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POR,
    ST_PROG_HI,
    ST_PROG_LO,
    ST_WAIT_INIT,
    ST_LOAD,
    ST_USER
  } fcs_state_e;

  localparam int REG_W = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IRQ  = 2'd2;

  localparam int CB_EN   = 0;
  localparam int CB_SEL  = 1;
  localparam int CB_MAN  = 2;
  localparam int CB_GO   = 3;

  localparam int IB_DONE = 0;
  localparam int IB_TMO  = 1;
endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[b];
        s2 <= RST_VAL[b];
      end else begin
        s1 <= d[b];
        s2 <= s1;
      end
    end
    assign q[b] = s2;
  end
endmodule

// File: rtl/fcs_regs.sv
module fcs_regs
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             init_s,
  input  logic             done_s,
  input  logic             busy,
  input  logic             user_mode,
  input  logic             set_done,
  input  logic             set_tmo,
  output logic             prog_manual,
  output logic             start_req,
  output logic             irq
);
  logic       port_en, pr_sel;
  logic [1:0] int_sts;
  logic [1:0] int_set, int_clr;

  assign start_req = reg_we && (reg_addr == ADDR_CTRL) && reg_wdata[CB_GO]
                     && reg_wdata[CB_EN] && reg_wdata[CB_SEL];

  always_comb begin
    int_set = '0;
    int_set[IB_DONE] = set_done;
    int_set[IB_TMO]  = set_tmo;
    int_clr = (reg_we && reg_addr == ADDR_IRQ) ? reg_wdata[1:0] : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_en     <= 1'b0;
      pr_sel      <= 1'b0;
      prog_manual <= 1'b1;
      int_sts     <= '0;
      reg_rdata   <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_CTRL) begin
        port_en     <= reg_wdata[CB_EN];
        pr_sel      <= reg_wdata[CB_SEL];
        prog_manual <= reg_wdata[CB_MAN];
      end
      int_sts <= (int_sts & ~int_clr) | int_set;
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= {1'b0, prog_manual, pr_sel, port_en};
        ADDR_STAT: reg_rdata <= {user_mode, busy, done_s, init_s};
        ADDR_IRQ:  reg_rdata <= {2'b00, int_sts};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign irq = |int_sts;

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_IRQ && reg_wdata[IB_DONE] && !set_done) |=> !int_sts[IB_DONE]);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int_sts[IB_TMO] && !(reg_we && reg_addr == ADDR_IRQ && reg_wdata[IB_TMO])) |=> int_sts[IB_TMO]);

  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    set_done |=> (int_sts[IB_DONE] && irq));
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
  import fcs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int POR_CYCLES = 16,
  parameter int PULSE_MIN  = 8,
  parameter int TIMEOUT    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              prog_manual,
  input  logic              init_s,
  input  logic              done_s,
  input  logic              cfg_valid,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              cfg_ready,
  output logic              fab_prog_n,
  output logic [DATA_W-1:0] fab_data,
  output logic              fab_we,
  output logic              set_done,
  output logic              set_tmo,
  output logic              busy,
  output logic              user_mode
);
  localparam int CNT_MAX = (POR_CYCLES > TIMEOUT) ? POR_CYCLES : TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_MIN - 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TIMEOUT - 1);
  localparam bit SKIP_POR = (POR_CYCLES == 0);

  fcs_state_e       state, state_nx;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             por_done;
  logic             accept;
  logic             need_por;

  assign cfg_ready = (state == ST_LOAD);
  assign accept    = cfg_valid && cfg_ready;
  assign busy      = (state != ST_IDLE) && (state != ST_USER);
  assign user_mode = (state == ST_USER);

  if (SKIP_POR) begin : g_no_por
    assign need_por = 1'b0;
  end else begin : g_por
    assign need_por = !por_done;
  end

  always_comb begin
    state_nx = state;
    cnt_clr  = 1'b0;
    set_done = 1'b0;
    set_tmo  = 1'b0;
    case (state)
      ST_IDLE: if (start_req) begin
        state_nx = need_por ? ST_POR : ST_PROG_HI;
        cnt_clr  = 1'b1;
      end
      ST_POR: if (cnt == POR_LAST) begin
        state_nx = ST_PROG_HI;
        cnt_clr  = 1'b1;
      end
      ST_PROG_HI: begin
        state_nx = ST_PROG_LO;
        cnt_clr  = 1'b1;
      end
      ST_PROG_LO: if (cnt >= PULSE_LAST && !init_s) begin
        state_nx = ST_WAIT_INIT;
        cnt_clr  = 1'b1;
      end else if (cnt == TMO_LAST) begin
        state_nx = ST_IDLE;
        set_tmo  = 1'b1;
      end
      ST_WAIT_INIT: if (init_s) begin
        state_nx = ST_LOAD;
        cnt_clr  = 1'b1;
      end else if (cnt == TMO_LAST) begin
        state_nx = ST_IDLE;
        set_tmo  = 1'b1;
      end
      ST_LOAD: if (done_s) begin
        state_nx = ST_USER;
        set_done = 1'b1;
      end else if (accept) begin
        cnt_clr  = 1'b1;
      end else if (cnt == TMO_LAST) begin
        state_nx = ST_IDLE;
        set_tmo  = 1'b1;
      end
      default: ;
    endcase
    if (start_req && state != ST_IDLE) begin
      state_nx = ST_PROG_HI;
      cnt_clr  = 1'b1;
      set_done = 1'b0;
      set_tmo  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      por_done <= 1'b0;
      fab_data <= '0;
      fab_we   <= 1'b0;
    end else begin
      state <= state_nx;
      if (cnt_clr) cnt <= '0;
      else if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
      if (state == ST_POR && state_nx != ST_POR) por_done <= 1'b1;
      fab_we <= accept;
      if (accept) fab_data <= cfg_data;
    end
  end

  always_comb begin
    case (state)
      ST_IDLE:    fab_prog_n = prog_manual;
      ST_PROG_LO: fab_prog_n = 1'b0;
      default:    fab_prog_n = 1'b1;
    endcase
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_req) |=> state == ST_IDLE);

  // R3
  pulse_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_INIT && $past(state) == ST_PROG_LO)
      |-> ($past(cnt) >= PULSE_LAST && !$past(init_s)));

  // R4
  load_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && $past(state) != ST_LOAD)
      |-> ($past(state) == ST_WAIT_INIT && $past(init_s)));

  // R5
  we_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    fab_we |-> $past(cfg_valid && cfg_ready));

  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    set_tmo |=> (state == ST_IDLE && !cfg_ready));
endmodule

// File: rtl/fabric_cfg_seq.sv
module fabric_cfg_seq
  import fcs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int POR_CYCLES = 16,
  parameter int PULSE_MIN  = 8,
  parameter int TIMEOUT    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [3:0]        reg_wdata,
  output logic [3:0]        reg_rdata,
  input  logic              cfg_valid,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              cfg_ready,
  output logic              fab_prog_n,
  input  logic              fab_init,
  input  logic              fab_done,
  output logic [DATA_W-1:0] fab_data,
  output logic              fab_we,
  output logic              irq
);
  logic init_s, done_s;
  logic prog_manual, start_req;
  logic set_done, set_tmo, busy, user_mode;

  fcs_sync #(.WIDTH(2), .RST_VAL(2'b00)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({fab_done, fab_init}),
    .q   ({done_s, init_s})
  );

  fcs_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .init_s      (init_s),
    .done_s      (done_s),
    .busy        (busy),
    .user_mode   (user_mode),
    .set_done    (set_done),
    .set_tmo     (set_tmo),
    .prog_manual (prog_manual),
    .start_req   (start_req),
    .irq         (irq)
  );

  fcs_fsm #(
    .DATA_W     (DATA_W),
    .POR_CYCLES (POR_CYCLES),
    .PULSE_MIN  (PULSE_MIN),
    .TIMEOUT    (TIMEOUT)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .prog_manual (prog_manual),
    .init_s      (init_s),
    .done_s      (done_s),
    .cfg_valid   (cfg_valid),
    .cfg_data    (cfg_data),
    .cfg_ready   (cfg_ready),
    .fab_prog_n  (fab_prog_n),
    .fab_data    (fab_data),
    .fab_we      (fab_we),
    .set_done    (set_done),
    .set_tmo     (set_tmo),
    .busy        (busy),
    .user_mode   (user_mode)
  );
endmodule

// File: tb/fabric_cfg_seq_bench.sv
module fabric_cfg_seq_bench;
  localparam int DW   = 16;
  localparam int POR  = 6;
  localparam int PMIN = 4;
  localparam int TMO  = 40;
  localparam int NEED = 8;
  localparam logic [3:0] C_EN = 4'd1, C_SEL = 4'd2, C_MAN = 4'd4, C_GO = 4'd8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] reg_rdata;
  logic cfg_valid = 1'b0;
  logic [DW-1:0] cfg_data = '0;
  logic cfg_ready, fab_prog_n, fab_we, irq;
  logic [DW-1:0] fab_data;
  logic fab_init, fab_done;

  always #10 clk = ~clk;

  fabric_cfg_seq #(.DATA_W(DW), .POR_CYCLES(POR), .PULSE_MIN(PMIN), .TIMEOUT(TMO))
  u_fabric_cfg_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
    .fab_prog_n(fab_prog_n), .fab_init(fab_init), .fab_done(fab_done),
    .fab_data(fab_data), .fab_we(fab_we), .irq(irq)
  );

  // fabric model
  logic stuck_high = 1'b0;
  logic [7:0] lo_cnt, hi_cnt, fcnt;
  logic [DW-1:0] cap [0:31];
  always @(posedge clk) begin
    if (rst) begin
      fab_init <= 1'b1; fab_done <= 1'b0; fcnt <= '0; lo_cnt <= '0; hi_cnt <= '0;
    end else if (!fab_prog_n) begin
      lo_cnt <= lo_cnt + 1'b1; hi_cnt <= '0; fcnt <= '0; fab_done <= 1'b0;
      if (lo_cnt >= 1 && !stuck_high) fab_init <= 1'b0;
    end else begin
      lo_cnt <= '0;
      if (!fab_init) begin
        hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= 2) fab_init <= 1'b1;
      end else hi_cnt <= '0;
      if (fab_we) begin cap[fcnt[4:0]] <= fab_data; fcnt <= fcnt + 1'b1; end
      if (fcnt >= NEED) fab_done <= 1'b1;
    end
  end

  // monitors
  int cyc = 0, low_total = 0, low_run = 0, last_low = 0, viol = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!fab_prog_n) begin
      low_total <= low_total + 1; low_run <= low_run + 1;
    end else begin
      if (low_run != 0) last_low <= low_run;
      low_run <= 0;
    end
    if (!rst && cfg_ready && (!fab_prog_n || !fab_init)) viol <= viol + 1;
  end

  int total = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = 4'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] word(input int seed, input int i);
    return DW'(16'hA500 ^ (i * 16'h0131) ^ (seed * 16'h1007));
  endfunction

  task automatic send(input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      bit got = 1'b0;
      int g = 0;
      cfg_valid = 1'b1; cfg_data = word(seed, i);
      while (!got && g < 200) begin
        got = cfg_ready;
        @(posedge clk); @(negedge clk);
        g++;
      end
    end
    cfg_valid = 1'b0;
  endtask

  task automatic wait_low(output int delay);
    int t0 = cyc;
    int g = 0;
    while (fab_prog_n && g < 200) begin @(negedge clk); g++; end
    delay = cyc - t0;
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!cfg_ready && g < 300) begin @(negedge clk); g++; end
  endtask

  task automatic wait_irq();
    int g = 0;
    while (!irq && g < 300) begin @(negedge clk); g++; end
  endtask

  task automatic t_reset();
    logic [3:0] d;
    chk("R10 prog line high after reset", {31'd0, fab_prog_n}, 32'd1);
    chk("R4 ready low after reset", {31'd0, cfg_ready}, 32'd0);
    chk("R7 irq low after reset", {31'd0, irq}, 32'd0);
    rd(2'd2, d); chk("R7 int status zero after reset", {28'd0, d}, 32'd0);
    rd(2'd1, d); chk("R11 status after reset", {28'd0, d}, 32'h1);
  endtask

  task automatic t_manual();
    logic [3:0] d;
    wr(2'd0, C_EN | C_SEL);
    chk("R10 manual low", {31'd0, fab_prog_n}, 32'd0);
    idle(8);
    rd(2'd1, d); chk("R11 init read low", {28'd0, d}, 32'h0);
    wr(2'd0, C_EN | C_SEL | C_MAN);
    chk("R10 manual high", {31'd0, fab_prog_n}, 32'd1);
    idle(10);
    rd(2'd1, d); chk("R11 init read high", {28'd0, d}, 32'h1);
  endtask

  task automatic t_ignored();
    logic [3:0] d;
    int base = low_total;
    wr(2'd0, C_MAN | C_GO | C_EN);
    idle(3);
    rd(2'd1, d); chk("R1 no start without select", {31'd0, d[2]}, 32'd0);
    wr(2'd0, C_MAN | C_GO | C_SEL);
    idle(3);
    rd(2'd1, d); chk("R1 no start without enable", {31'd0, d[2]}, 32'd0);
    idle(20);
    chk("R1 program line never moved", 32'(low_total - base), 32'd0);
  endtask

  task automatic check_words(input string req, input int seed);
    for (int i = 0; i < NEED; i++)
      chk(req, {16'd0, cap[i]}, {16'd0, word(seed, i)});
  endtask

  task automatic t_first_config();
    logic [3:0] d;
    int dly;
    int v0 = viol;
    wr(2'd0, C_EN | C_SEL | C_MAN | C_GO);
    rd(2'd1, d); chk("R1 busy after valid start", {31'd0, d[2]}, 32'd1);
    wait_low(dly);
    chk("R2 power-on wait honoured", {31'd0, (dly + 2) >= POR}, 32'd1);
    wait_ready();
    chk("R4 ready reached", {31'd0, cfg_ready}, 32'd1);
    chk("R3 pulse width", {31'd0, last_low >= PMIN}, 32'd1);
    send(1, NEED);
    wait_irq();
    chk("R6 irq raised", {31'd0, irq}, 32'd1);
    chk("R4 ready low in user mode", {31'd0, cfg_ready}, 32'd0);
    chk("R4 no ready while program low or init low", 32'(viol - v0), 32'd0);
    rd(2'd2, d); chk("R6 done bit", {28'd0, d}, 32'h1);
    rd(2'd1, d); chk("R6 R11 status in user mode", {28'd0, d}, 32'hB);
    check_words("R5 word order", 1);
  endtask

  task automatic t_w1c();
    logic [3:0] d;
    wr(2'd2, 4'd0);
    rd(2'd2, d); chk("R7 write zero keeps bit", {28'd0, d}, 32'h1);
    chk("R7 irq still high", {31'd0, irq}, 32'd1);
    wr(2'd2, 4'd1);
    rd(2'd2, d); chk("R7 write one clears bit", {28'd0, d}, 32'h0);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_restart();
    logic [3:0] d;
    int dly;
    wr(2'd0, C_EN | C_SEL | C_MAN | C_GO);
    wait_low(dly);
    chk("R2 restart skips power-on wait", {31'd0, dly < POR}, 32'd1);
    wait_ready();
    send(2, 3);
    wr(2'd0, C_EN | C_SEL | C_MAN | C_GO);
    chk("R9 ready dropped by restart", {31'd0, cfg_ready}, 32'd0);
    wait_low(dly);
    chk("R9 program pulse restarted", {31'd0, fab_prog_n}, 32'd0);
    wait_ready();
    send(3, NEED);
    wait_irq();
    rd(2'd2, d); chk("R9 done after restarted load", {28'd0, d}, 32'h1);
    check_words("R9 R5 fresh words after restart", 3);
    wr(2'd2, 4'd3);
  endtask

  task automatic t_timeout();
    logic [3:0] d;
    stuck_high = 1'b1;
    wr(2'd0, C_EN | C_SEL | C_MAN | C_GO);
    wait_irq();
    rd(2'd2, d); chk("R8 timeout bit only", {28'd0, d}, 32'h2);
    rd(2'd1, d); chk("R8 not busy after timeout", {31'd0, d[2]}, 32'd0);
    chk("R8 program line at idle level", {31'd0, fab_prog_n}, 32'd1);
    chk("R8 ready low after timeout", {31'd0, cfg_ready}, 32'd0);
    stuck_high = 1'b0;
    wr(2'd2, 4'd2);
    rd(2'd2, d); chk("R7 timeout bit cleared", {28'd0, d}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_manual();
    t_ignored();
    t_first_config();
    t_w1c();
    t_restart();
    t_timeout();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule